// File: doc/BRIEF.md
# Extended float round, normalize and pack unit

The block converts an unpacked floating-point value into a packed 48-bit extended format. It takes a signed, left-justified 48-bit mantissa and a signed exponent. It normalizes the value, one left shift per cycle. It then rounds to a 40-bit two's-complement mantissa and applies the exponent limits. The result is three 16-bit words and an overflow flag. Input and output each use a valid/ready handshake.

An unpack path runs beside the pack path as purely combinational logic. It splits three packed words back into a left-justified signed mantissa and a sign-extended 8-bit exponent. Arithmetic on mantissas happens upstream, outside this block.

Top module: `fpx_pack_unit`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: An operand is taken on a clock edge where in_valid_i and in_ready_o are both 1. From that edge, in_ready_o stays 0 until the result is accepted. The words and the flag stay stable, with out_valid_o at 1, until out_ready_i is 1.
- R3: A nonzero mantissa is shifted left, and the exponent decremented, until bit 47 differs from bit 46. A mantissa of -1 needs 47 such shifts.
- R4: A zero mantissa gives three zero words and flag 0, whatever the exponent.
- R5: Rounding adds 0x80 to the 48-bit mantissa when bit 47 is 0, and 0x7F when bit 47 is 1. Bits 7..0 are then cleared.
- R6: If rounding changes bit 47, the mantissa is shifted right logically by one and the exponent is incremented.
- R7: If rounding leaves bit 47 unchanged, the mantissa is normalized again as in R3.
- R8: Layout: word 0 holds mantissa bits 47..32 and word 1 holds bits 31..16. Word 2 holds mantissa bits 15..8 in its bits 15..8, exponent bits 6..0 in its bits 7..1, and the exponent sign in its bit 0.
- R9: A final exponent below -128 gives three zero words with the flag at 1. An exponent of exactly -128 packs normally.
- R10: A final exponent above 127 saturates with the flag at 1. A positive value becomes 0x7FFF,0xFFFF,0xFFFE and a negative value becomes 0x8000,0x0000,0x00FE. An exponent of exactly 127 packs normally.
- R11: Unpack gives upk_mant_o = {w0, w1, w2[15:8], 8'h00} and upk_exp_o = {w2[0], w2[7:1]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand valid |
| in_ready_o | output | 1 | Unit idle, can take an operand |
| in_mant_i | input | 48 | Signed left-justified mantissa |
| in_exp_i | input | 16 | Signed exponent |
| out_valid_o | output | 1 | Packed result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| out_w0_o | output | 16 | Packed word 0 |
| out_w1_o | output | 16 | Packed word 1 |
| out_w2_o | output | 16 | Packed word 2 |
| out_ovf_o | output | 1 | Exponent overflow or underflow |
| upk_w0_i | input | 16 | Unpack word 0 |
| upk_w1_i | input | 16 | Unpack word 1 |
| upk_w2_i | input | 16 | Unpack word 2 |
| upk_mant_o | output | 48 | Unpacked left-justified mantissa |
| upk_exp_o | output | 8 | Unpacked signed exponent |

## Verification
Every fault in the shift loop shows up in the exponent field of word 2 as a count that is off by one or more. It is visible as soon as out_valid_o rises, at most about 100 cycles after the operand is accepted. The test that the two top mantissa bits differ in every nonzero result catches a stop that comes too early. A wrong rounding bias or wrong carry handling changes word 2 bits 15..8 or the exponent field of the same result. A wrong state in the handshake shows as in_ready_o and out_valid_o both high, or as output words that change while out_ready_i is low.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_NORM,
    ST_ROUND,
    ST_DONE
  } fpx_state_e;
endpackage

// File: rtl/fpx_norm_step.sv
module fpx_norm_step #(
  parameter int unsigned MW = 48,
  parameter int unsigned EW = 18
) (
  input  logic [MW-1:0]        m_i,
  input  logic signed [EW-1:0] e_i,
  output logic                 zero_o,
  output logic                 norm_o,
  output logic [MW-1:0]        m_o,
  output logic signed [EW-1:0] e_o
);
  assign zero_o = (m_i == '0);
  assign norm_o = m_i[MW-1] ^ m_i[MW-2];
  assign m_o    = m_i << 1;
  assign e_o    = e_i - EW'(1);
endmodule

// File: rtl/fpx_rounder.sv
module fpx_rounder #(
  parameter int unsigned MW  = 48,
  parameter int unsigned PMW = 40,
  parameter int unsigned EW  = 18
) (
  input  logic [MW-1:0]        m_i,
  input  logic signed [EW-1:0] e_i,
  output logic [MW-1:0]        m_o,
  output logic signed [EW-1:0] e_o,
  output logic                 flip_o
);
  localparam int unsigned RW = MW - PMW;

  logic [MW-1:0] bias, sum, masked, shr;

  // negative values get half LSB minus one
  assign bias   = m_i[MW-1] ? {{(MW-RW+1){1'b0}}, {(RW-1){1'b1}}}
                            : {{(MW-RW){1'b0}}, 1'b1, {(RW-1){1'b0}}};
  assign sum    = m_i + bias;
  assign masked = {sum[MW-1:RW], {RW{1'b0}}};
  assign shr    = masked >> 1;
  assign flip_o = masked[MW-1] ^ m_i[MW-1];

  always_comb begin
    if (flip_o) begin
      m_o = {shr[MW-1:RW], {RW{1'b0}}};
      e_o = e_i + EW'(1);
    end else begin
      m_o = masked;
      e_o = e_i;
    end
  end
endmodule

// File: rtl/fpx_packer.sv
module fpx_packer #(
  parameter int unsigned PMW = 40,
  parameter int unsigned PEW = 8,
  parameter int unsigned EW  = 18
) (
  input  logic [PMW-1:0]       mant_i,
  input  logic signed [EW-1:0] e_i,
  output logic [PMW+PEW-1:0]   pk_o,
  output logic                 ovf_o
);
  localparam int EMAX = (2 ** (PEW - 1)) - 1;
  localparam int EMIN = -(2 ** (PEW - 1));

  logic [PMW-1:0] pm;
  logic [PEW-1:0] pe;

  always_comb begin
    pm    = '0;
    pe    = '0;
    ovf_o = 1'b0;
    if (mant_i == '0) begin
      pm = '0;
    end else if (int'(e_i) < EMIN) begin
      ovf_o = 1'b1;
    end else if (int'(e_i) > EMAX) begin
      ovf_o = 1'b1;
      pm    = mant_i[PMW-1] ? {1'b1, {(PMW-1){1'b0}}} : {1'b0, {(PMW-1){1'b1}}};
      pe    = PEW'(EMAX);
    end else begin
      pm = mant_i;
      pe = e_i[PEW-1:0];
    end
  end

  // exponent rotated: sign to bit 0
  assign pk_o = {pm, pe[PEW-2:0], pe[PEW-1]};
endmodule

// File: rtl/fpx_unpacker.sv
module fpx_unpacker #(
  parameter int unsigned MW  = 48,
  parameter int unsigned PMW = 40,
  parameter int unsigned PEW = 8
) (
  input  logic [PMW+PEW-1:0] pk_i,
  output logic [MW-1:0]      mant_o,
  output logic [PEW-1:0]     exp_o
);
  assign mant_o = {pk_i[PMW+PEW-1:PEW], {(MW-PMW){1'b0}}};
  assign exp_o  = {pk_i[0], pk_i[PEW-1:1]};
endmodule

// File: rtl/fpx_pack_unit.sv
module fpx_pack_unit
  import fpx_pkg::*;
#(
  parameter int unsigned MANT_W = 48,
  parameter int unsigned PK_MW  = 40,
  parameter int unsigned PK_EW  = 8,
  parameter int unsigned EXP_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [MANT_W-1:0]   in_mant_i,
  input  logic [EXP_W-1:0]    in_exp_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [WORD_W-1:0]   out_w0_o,
  output logic [WORD_W-1:0]   out_w1_o,
  output logic [WORD_W-1:0]   out_w2_o,
  output logic                out_ovf_o,
  input  logic [WORD_W-1:0]   upk_w0_i,
  input  logic [WORD_W-1:0]   upk_w1_i,
  input  logic [WORD_W-1:0]   upk_w2_i,
  output logic [MANT_W-1:0]   upk_mant_o,
  output logic [PK_EW-1:0]    upk_exp_o
);
  localparam int unsigned IEW       = EXP_W + 2;
  localparam int unsigned PK_W      = PK_MW + PK_EW;
  localparam int unsigned NWORDS    = PK_W / WORD_W;
  localparam int unsigned MAX_SHIFT = MANT_W - 1;
  localparam int unsigned CW        = $clog2(MANT_W);

  fpx_state_e           state_q;
  logic                 renorm_q;
  logic [CW-1:0]        cnt_q;
  logic [MANT_W-1:0]    m_q;
  logic signed [IEW-1:0] e_q;

  logic                 n_zero, n_norm, r_flip;
  logic [MANT_W-1:0]    n_m, r_m;
  logic signed [IEW-1:0] n_e, r_e;
  logic [PK_W-1:0]      pk, upk;

  fpx_norm_step #(.MW(MANT_W), .EW(IEW)) u_norm (
    .m_i(m_q), .e_i(e_q), .zero_o(n_zero), .norm_o(n_norm), .m_o(n_m), .e_o(n_e)
  );

  fpx_rounder #(.MW(MANT_W), .PMW(PK_MW), .EW(IEW)) u_rnd (
    .m_i(m_q), .e_i(e_q), .m_o(r_m), .e_o(r_e), .flip_o(r_flip)
  );

  fpx_packer #(.PMW(PK_MW), .PEW(PK_EW), .EW(IEW)) u_pack (
    .mant_i(m_q[MANT_W-1 -: PK_MW]), .e_i(e_q), .pk_o(pk), .ovf_o(out_ovf_o)
  );

  assign upk = {upk_w0_i, upk_w1_i, upk_w2_i};

  fpx_unpacker #(.MW(MANT_W), .PMW(PK_MW), .PEW(PK_EW)) u_unpack (
    .pk_i(upk), .mant_o(upk_mant_o), .exp_o(upk_exp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      renorm_q <= 1'b0;
      cnt_q    <= '0;
      m_q      <= '0;
      e_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          m_q      <= in_mant_i;
          e_q      <= {{2{in_exp_i[EXP_W-1]}}, in_exp_i};
          renorm_q <= 1'b0;
          cnt_q    <= '0;
          state_q  <= ST_NORM;
        end
        ST_NORM: begin
          if (n_zero) begin
            e_q     <= '0;
            state_q <= ST_DONE;
          end else if (n_norm || cnt_q == CW'(MAX_SHIFT)) begin
            state_q <= renorm_q ? ST_DONE : ST_ROUND;
          end else begin
            m_q   <= n_m;
            e_q   <= n_e;
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_ROUND: begin
          m_q <= r_m;
          e_q <= r_e;
          if (r_flip) begin
            state_q <= ST_DONE;
          end else begin
            renorm_q <= 1'b1;
            cnt_q    <= '0;
            state_q  <= ST_NORM;
          end
        end
        ST_DONE: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_DONE);

  logic [WORD_W-1:0] words [NWORDS];
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign words[g] = pk[PK_W-1-g*WORD_W -: WORD_W];
  end

  assign out_w0_o = words[0];
  assign out_w1_o = words[1];
  assign out_w2_o = words[2];
endmodule

// File: rtl/fpx_pack_unit_chk.sv
module fpx_pack_unit_chk #(
  parameter int unsigned WW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [WW-1:0] out_w0_o,
  input logic [WW-1:0] out_w1_o,
  input logic [WW-1:0] out_w2_o,
  input logic          out_ovf_o
);
  AST_READY_VALID_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));  // R2
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !in_ready_o);  // R2
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_w0_o) && $stable(out_w1_o)
      && $stable(out_w2_o) && $stable(out_ovf_o));  // R2
  AST_NORMALIZED_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_w0_o != '0 |-> out_w0_o[WW-1] != out_w0_o[WW-2]);  // R3
  AST_ZERO_WORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_w0_o == '0 |-> out_w1_o == '0 && out_w2_o == '0);  // R4
  AST_SAT_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ovf_o && out_w0_o != '0 |-> out_w2_o[7:0] == 8'hFE);  // R10
endmodule

bind fpx_pack_unit fpx_pack_unit_chk #(.WW(fpx_pkg::WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_w0_o(out_w0_o),
  .out_w1_o(out_w1_o), .out_w2_o(out_w2_o), .out_ovf_o(out_ovf_o)
);

// File: tb/fpx_pack_unit_tb.sv
module fpx_pack_unit_tb_top;
  localparam time TCK = 8ns;

  typedef struct packed {
    logic [7:0]         req;
    logic [47:0]        mant;
    logic signed [15:0] ex;
    logic [15:0]        w0;
    logic [15:0]        w1;
    logic [15:0]        w2;
    logic               ovf;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'd4,  48'h000000000000,  16'sd55,  16'h0000, 16'h0000, 16'h0000, 1'b0}, // R4
    '{8'd8,  48'h400000000000,  16'sd1,   16'h4000, 16'h0000, 16'h0002, 1'b0}, // R8
    '{8'd3,  48'h000000010000,  16'sd0,   16'h4000, 16'h0000, 16'h00C5, 1'b0}, // R3
    '{8'd5,  48'h4000000000C0,  16'sd3,   16'h4000, 16'h0000, 16'h0106, 1'b0}, // R5
    '{8'd6,  48'h7FFFFFFFFF80,  16'sd5,   16'h4000, 16'h0000, 16'h000C, 1'b0}, // R6
    '{8'd5,  48'h800000000000,  16'sd2,   16'h8000, 16'h0000, 16'h0004, 1'b0}, // R5
    '{8'd5,  48'hBFFFFFFFFF80,  16'sd0,   16'hBFFF, 16'hFFFF, 16'hFF00, 1'b0}, // R5
    '{8'd7,  48'hBFFFFFFFFF81,  16'sd4,   16'h8000, 16'h0000, 16'h0006, 1'b0}, // R7
    '{8'd10, 48'h400000000000,  16'sd128, 16'h7FFF, 16'hFFFF, 16'hFFFE, 1'b1}, // R10
    '{8'd10, 48'h800000000000,  16'sd200, 16'h8000, 16'h0000, 16'h00FE, 1'b1}, // R10
    '{8'd9,  48'h400000000000, -16'sd129, 16'h0000, 16'h0000, 16'h0000, 1'b1}, // R9
    '{8'd9,  48'h400000000000, -16'sd128, 16'h4000, 16'h0000, 16'h0001, 1'b0}, // R9
    '{8'd10, 48'h400000000000,  16'sd127, 16'h4000, 16'h0000, 16'h00FE, 1'b0}, // R10
    '{8'd9,  48'h000000000100, -16'sd100, 16'h0000, 16'h0000, 16'h0000, 1'b1}, // R9
    '{8'd3,  48'hFFFFFFFF0000,  16'sd10,  16'h8000, 16'h0000, 16'h00D7, 1'b0}, // R3
    '{8'd10, 48'h7FFFFFFFFF80,  16'sd127, 16'h7FFF, 16'hFFFF, 16'hFFFE, 1'b1}, // R10
    '{8'd3,  48'hFFFFFFFFFFFF,  16'sd0,   16'h8000, 16'h0000, 16'h00A3, 1'b0}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_mant = '0;
  logic [15:0] in_exp = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] w0, w1, w2;
  logic        ovf;
  logic [15:0] u0 = '0, u1 = '0, u2 = '0;
  logic [47:0] u_mant;
  logic [7:0]  u_exp;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(TCK/2) clk = ~clk;

  fpx_pack_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_mant_i(in_mant), .in_exp_i(in_exp), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_w0_o(w0), .out_w1_o(w1), .out_w2_o(w2),
    .out_ovf_o(ovf), .upk_w0_i(u0), .upk_w1_i(u1), .upk_w2_i(u2),
    .upk_mant_o(u_mant), .upk_exp_o(u_exp)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // returns 1 when out_valid seen
  task automatic push(input logic [47:0] m, input logic [15:0] e, output bit got);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_mant  = m;
    in_exp   = e;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (out_valid) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    bit got;
    logic [63:0] a, x;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready === 1'b1, "R1 ready", 64'(in_ready), 64'd1);
    check(out_valid === 1'b0, "R1 valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      push(VECS[k].mant, VECS[k].ex, got);
      a = {15'd0, got, w0, w1, w2, ovf};
      x = {15'd0, 1'b1, VECS[k].w0, VECS[k].w1, VECS[k].w2, VECS[k].ovf};
      check(a === x, $sformatf("R%0d vec%0d", VECS[k].req, k), a, x);
      pop();
    end

    // R2 busy after take, result held while out_ready low
    @(negedge clk);
    in_mant = 48'h000000010000; in_exp = 16'sd0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready === 1'b0, "R2 busy", 64'(in_ready), 64'd0);
    for (int i = 0; i < 300 && !out_valid; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    a = {15'd0, out_valid, w0, w1, w2, ovf};
    x = {15'd0, 1'b1, 16'h4000, 16'h0000, 16'h00C5, 1'b0};
    check(a === x, "R2 hold", a, x);
    check(in_ready === 1'b0, "R2 no take while full", 64'(in_ready), 64'd0);
    pop();
    check(out_valid === 1'b0 && in_ready === 1'b1, "R2 release",
          64'({out_valid, in_ready}), 64'b01);

    // R11 unpack
    u0 = 16'h4000; u1 = 16'h0000; u2 = 16'h01C5; #1;
    a = {8'd0, u_mant, u_exp}; x = {8'd0, 48'h400000000100, 8'hE2};
    check(a === x, "R11 neg exp", a, x);
    u0 = 16'h7FFF; u1 = 16'hFFFF; u2 = 16'hFFFE; #1;
    a = {8'd0, u_mant, u_exp}; x = {8'd0, 48'h7FFFFFFFFF00, 8'h7F};
    check(a === x, "R11 max exp", a, x);
    u0 = 16'h8000; u1 = 16'h1234; u2 = 16'hAB01; #1;
    a = {8'd0, u_mant, u_exp}; x = {8'd0, 48'h80001234AB00, 8'h80};
    check(a === x, "R11 min exp", a, x);

    finish_run();
  end

  initial begin
    #(TCK * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end
endmodule